// File: doc/BRIEF.md
# 9/7 Lifting Wavelet Core (1-D, forward)

This block performs a forward one-dimensional biorthogonal 9/7 wavelet transform on a stream of signed fixed-point samples. Samples arrive one per accepted cycle. Each line of `LINE_LEN` samples is grouped into (even, odd) pairs. The pairs pass through a chain of four lifting stages, predict then update and then predict and update again, and a final scaling stage. Each pair yields one low-pass coefficient and one high-pass coefficient. At both ends of a line, a missing neighbour is replaced by its mirror image, so every line is transformed on its own. An `N`-sample line gives exactly `N/2` coefficient pairs.

All arithmetic is signed two's complement. Lifting and scale constants are signed 16-bit values with 14 fractional bits. Every product is shifted right arithmetically by 14 bits, which rounds toward minus infinity. It is then cut back to the internal width of `SAMPLE_W + GUARD_W` bits. The core is meant to sit in front of a row/column scheduler that reuses it for both image directions. Lines may follow each other with no idle cycles, and the input may pause at any sample.

Top module: `dwt97_core`

## Requirements
- R1: While the reset is asserted and until the first output, `o_valid`, `o_first` and `o_last` are 0 and `o_lo` and `o_hi` are 0.
- R2: Accepted samples are counted from the start of each line. Position 2k is the even member and position 2k+1 is the odd member of pair k. A line holds `LINE_LEN` samples.
- R3: A predict step with constant C replaces the detail value: d' = wrap(d + wrap(floor(C*(a_k + a_right)/16384))). Here a_right is the approximation of the following pair, and wrap keeps the low `SAMPLE_W+GUARD_W` bits as a signed value.
- R4: An update step with constant C replaces the approximation: a' = wrap(a + wrap(floor(C*(d_left + d_k)/16384))). Here d_left is the detail of the preceding pair as already produced by the predict step just before.
- R5: The steps run in this order with these 16-bit constants: predict −25987, update −868, predict 14466, update 7266. The first predict takes the odd samples as detail and the even samples as approximation.
- R6: After lifting, `o_lo` = wrap(floor(18835*a/16384)) and `o_hi` = wrap(floor(14252*d/16384)).
- R7: In both predict steps, the last pair of a line uses its own approximation as the missing right neighbour.
- R8: In both update steps, the first pair of a line uses its own detail as the missing left neighbour.
- R9: Each line gives exactly `LINE_LEN/2` output strobes, in pair order. `o_first` marks pair 0 and `o_last` marks the final pair. No strobe follows in the cycle after `o_last`.
- R10: The strobe carrying `o_last` appears 7 clock cycles after the rising edge that accepts the final sample of its line.
- R11: Cycles with `i_valid` low have no effect, whatever `i_sample` holds. A line sent with pauses gives the same coefficients as the same line sent without pauses.
- R12: Lines sent back to back with no idle cycles are transformed independently. The coefficients of a line do not depend on the line before it.
- R13: While `o_valid` is low, `o_lo` and `o_hi` hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| i_valid | input | 1 | Sample strobe |
| i_sample | input | SAMPLE_W | Signed input sample |
| o_valid | output | 1 | Coefficient pair strobe |
| o_first | output | 1 | Strobed pair is pair 0 of its line |
| o_last | output | 1 | Strobed pair is the final pair of its line |
| o_lo | output | SAMPLE_W+GUARD_W | Signed low-pass coefficient |
| o_hi | output | SAMPLE_W+GUARD_W | Signed high-pass coefficient |

## Verification
Each predict stage can see two events in one cycle. The pair that closes a line both completes the interior prediction of the previous pair and arms the mirrored tail for itself. In streaming without gaps, the next line's opening samples then enter the splitter while that tail is still inside the lifting chain. The bench provokes this with zero-gap back-to-back lines, with impulses placed at every position and with random lines. It judges every coefficient bit-exactly against an integer model of the lifting equations. It also judges the tail strobe's cycle against the accept edge of the final sample and the line markers against the pair order.

// File: rtl/dwt97_pkg.sv
`timescale 1ns/1ps
package dwt97_pkg;
  localparam int CW   = 16;   // coefficient width, signed
  localparam int FRAC = 14;   // fractional bits of every coefficient
  localparam int LIFT_PAIRS = 2;

  typedef logic signed [CW-1:0] coef_t;

  localparam coef_t C_ALPHA = -16'sd25987;
  localparam coef_t C_BETA  = -16'sd868;
  localparam coef_t C_GAMMA =  16'sd14466;
  localparam coef_t C_DELTA =  16'sd7266;
  localparam coef_t C_KLO   =  16'sd18835;
  localparam coef_t C_KHI   =  16'sd14252;
endpackage

// File: rtl/dwt97_cmul.sv
`timescale 1ns/1ps
// Signed constant multiply, floor by FRAC bits, wrap to IW bits.
module dwt97_cmul
  import dwt97_pkg::*;
#(
  parameter int    IW   = 16,
  parameter coef_t COEF = 16'sd0
) (
  input  logic signed [IW:0]   i_v,
  output logic signed [IW-1:0] o_p
);
  localparam int PW = IW + CW + 1;

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = {{CW{i_v[IW]}}, i_v} * {{(IW+1){COEF[CW-1]}}, COEF};
  end

  assign o_p = IW'(prod >>> FRAC);
endmodule

// File: rtl/dwt97_pair_split.sv
`timescale 1ns/1ps
// Groups the sample stream into (even, odd) pairs and tags line ends.
module dwt97_pair_split #(
  parameter int LINE_LEN = 8,
  parameter int SAMPLE_W = 12,
  parameter int IW       = 16
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       i_valid,
  input  logic signed [SAMPLE_W-1:0] i_sample,
  output logic                       o_valid,
  output logic signed [IW-1:0]       o_even,
  output logic signed [IW-1:0]       o_odd,
  output logic                       o_first,
  output logic                       o_last
);
  localparam int PAIRS = LINE_LEN / 2;
  localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic              phase_q, phase_d;
  logic [PW-1:0]     pidx_q, pidx_d;
  logic signed [IW-1:0] even_q, even_d;
  logic signed [IW-1:0] sx;
  logic              emit;

  assign sx = IW'(i_sample);

  always_comb begin
    phase_d = phase_q;
    pidx_d  = pidx_q;
    even_d  = even_q;
    emit    = 1'b0;
    if (i_valid) begin
      if (!phase_q) begin
        even_d  = sx;
        phase_d = 1'b1;
      end else begin
        emit    = 1'b1;
        phase_d = 1'b0;
        pidx_d  = (pidx_q == PW'(PAIRS-1)) ? '0 : pidx_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      pidx_q  <= '0;
      even_q  <= '0;
      o_valid <= 1'b0;
      o_even  <= '0;
      o_odd   <= '0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pidx_q  <= pidx_d;
      even_q  <= even_d;
      o_valid <= emit;
      if (emit) begin
        o_even  <= even_q;
        o_odd   <= sx;
        o_first <= (pidx_q == '0);
        o_last  <= (pidx_q == PW'(PAIRS-1));
      end
    end
  end
endmodule

// File: rtl/dwt97_predict.sv
`timescale 1ns/1ps
// Predict step: needs the next pair's approximation, so it emits pair k-1
// when pair k arrives and flushes the final pair one cycle later with a
// mirrored right neighbour.
module dwt97_predict
  import dwt97_pkg::*;
#(
  parameter int    IW   = 16,
  parameter coef_t COEF = 16'sd0
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 i_valid,
  input  logic signed [IW-1:0] i_a,
  input  logic signed [IW-1:0] i_d,
  input  logic                 i_first,
  input  logic                 i_last,
  output logic                 o_valid,
  output logic signed [IW-1:0] o_a,
  output logic signed [IW-1:0] o_d,
  output logic                 o_first,
  output logic                 o_last
);
  logic signed [IW-1:0] ha_q, hd_q;
  logic                 hf_q, pend_q, pend_d;
  logic signed [IW-1:0] right;
  logic signed [IW:0]   nsum;
  logic signed [IW-1:0] corr, d_new;
  logic                 emit;

  always_comb begin
    right  = pend_q ? ha_q : i_a;
    nsum   = (IW+1)'(ha_q) + (IW+1)'(right);
    emit   = (i_valid && !i_first) || pend_q;
    pend_d = i_valid ? i_last : 1'b0;
    d_new  = hd_q + corr;
  end

  dwt97_cmul #(.IW(IW), .COEF(COEF)) u_mul (.i_v(nsum), .o_p(corr));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ha_q    <= '0;
      hd_q    <= '0;
      hf_q    <= 1'b0;
      pend_q  <= 1'b0;
      o_valid <= 1'b0;
      o_a     <= '0;
      o_d     <= '0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      o_valid <= emit;
      if (emit) begin
        o_a     <= ha_q;
        o_d     <= d_new;
        o_first <= hf_q;
        o_last  <= pend_q;
      end
      if (i_valid) begin
        ha_q <= i_a;
        hd_q <= i_d;
        hf_q <= i_first;
      end
    end
  end
endmodule

// File: rtl/dwt97_update.sv
`timescale 1ns/1ps
// Update step: uses the previous pair's detail, mirrored on the first pair.
module dwt97_update
  import dwt97_pkg::*;
#(
  parameter int    IW   = 16,
  parameter coef_t COEF = 16'sd0
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 i_valid,
  input  logic signed [IW-1:0] i_a,
  input  logic signed [IW-1:0] i_d,
  input  logic                 i_first,
  input  logic                 i_last,
  output logic                 o_valid,
  output logic signed [IW-1:0] o_a,
  output logic signed [IW-1:0] o_d,
  output logic                 o_first,
  output logic                 o_last
);
  logic signed [IW-1:0] dprev_q, left, corr, a_new;
  logic signed [IW:0]   nsum;

  always_comb begin
    left  = i_first ? i_d : dprev_q;
    nsum  = (IW+1)'(left) + (IW+1)'(i_d);
    a_new = i_a + corr;
  end

  dwt97_cmul #(.IW(IW), .COEF(COEF)) u_mul (.i_v(nsum), .o_p(corr));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dprev_q <= '0;
      o_valid <= 1'b0;
      o_a     <= '0;
      o_d     <= '0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        dprev_q <= i_d;
        o_a     <= a_new;
        o_d     <= i_d;
        o_first <= i_first;
        o_last  <= i_last;
      end
    end
  end
endmodule

// File: rtl/dwt97_core.sv
`timescale 1ns/1ps
module dwt97_core
  import dwt97_pkg::*;
#(
  parameter int LINE_LEN = 8,
  parameter int SAMPLE_W = 12,
  parameter int GUARD_W  = 4
) (
  input  logic                                clk,
  input  logic                                rst_ni,
  input  logic                                i_valid,
  input  logic signed [SAMPLE_W-1:0]          i_sample,
  output logic                                o_valid,
  output logic                                o_first,
  output logic                                o_last,
  output logic signed [SAMPLE_W+GUARD_W-1:0]  o_lo,
  output logic signed [SAMPLE_W+GUARD_W-1:0]  o_hi
);
  localparam int IW     = SAMPLE_W + GUARD_W;
  localparam int STAGES = 2 * LIFT_PAIRS;
  localparam coef_t PRED_C [LIFT_PAIRS] = '{C_ALPHA, C_GAMMA};
  localparam coef_t UPD_C  [LIFT_PAIRS] = '{C_BETA,  C_DELTA};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic                 st_v [STAGES+1];
  logic signed [IW-1:0] st_a [STAGES+1];
  logic signed [IW-1:0] st_d [STAGES+1];
  logic                 st_f [STAGES+1];
  logic                 st_l [STAGES+1];

  dwt97_pair_split #(.LINE_LEN(LINE_LEN), .SAMPLE_W(SAMPLE_W), .IW(IW)) u_split (
    .clk(clk), .rst_ni(rst_n), .i_valid(i_valid), .i_sample(i_sample),
    .o_valid(st_v[0]), .o_even(st_a[0]), .o_odd(st_d[0]),
    .o_first(st_f[0]), .o_last(st_l[0])
  );

  for (genvar g = 0; g < LIFT_PAIRS; g++) begin : g_lift
    dwt97_predict #(.IW(IW), .COEF(PRED_C[g])) u_pred (
      .clk(clk), .rst_ni(rst_n),
      .i_valid(st_v[2*g]), .i_a(st_a[2*g]), .i_d(st_d[2*g]),
      .i_first(st_f[2*g]), .i_last(st_l[2*g]),
      .o_valid(st_v[2*g+1]), .o_a(st_a[2*g+1]), .o_d(st_d[2*g+1]),
      .o_first(st_f[2*g+1]), .o_last(st_l[2*g+1])
    );
    dwt97_update #(.IW(IW), .COEF(UPD_C[g])) u_upd (
      .clk(clk), .rst_ni(rst_n),
      .i_valid(st_v[2*g+1]), .i_a(st_a[2*g+1]), .i_d(st_d[2*g+1]),
      .i_first(st_f[2*g+1]), .i_last(st_l[2*g+1]),
      .o_valid(st_v[2*g+2]), .o_a(st_a[2*g+2]), .o_d(st_d[2*g+2]),
      .o_first(st_f[2*g+2]), .o_last(st_l[2*g+2])
    );
  end

  // scaling stage
  logic signed [IW-1:0] lo_p, hi_p;

  dwt97_cmul #(.IW(IW), .COEF(C_KLO)) u_klo (.i_v((IW+1)'(st_a[STAGES])), .o_p(lo_p));
  dwt97_cmul #(.IW(IW), .COEF(C_KHI)) u_khi (.i_v((IW+1)'(st_d[STAGES])), .o_p(hi_p));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_first <= 1'b0;
      o_last  <= 1'b0;
      o_lo    <= '0;
      o_hi    <= '0;
    end else begin
      o_valid <= st_v[STAGES];
      if (st_v[STAGES]) begin
        o_first <= st_f[STAGES];
        o_last  <= st_l[STAGES];
        o_lo    <= lo_p;
        o_hi    <= hi_p;
      end
    end
  end
endmodule

// File: rtl/dwt97_core_chk.sv
`timescale 1ns/1ps
module dwt97_core_chk #(
  parameter int LINE_LEN = 8,
  parameter int OW       = 16
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 i_valid,
  input logic                 o_valid,
  input logic                 o_first,
  input logic                 o_last,
  input logic signed [OW-1:0] o_lo,
  input logic signed [OW-1:0] o_hi
);
  localparam int PAIRS = LINE_LEN / 2;
  localparam int NW    = $clog2(LINE_LEN);
  localparam int QW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [NW-1:0] in_cnt;
  logic [QW-1:0] out_cnt;
  logic          end_pulse;

  assign end_pulse = i_valid && (in_cnt == NW'(LINE_LEN-1));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= '0;
      out_cnt <= '0;
    end else begin
      if (i_valid) in_cnt <= end_pulse ? '0 : in_cnt + NW'(1);
      if (o_valid) out_cnt <= (out_cnt == QW'(PAIRS-1)) ? '0 : out_cnt + QW'(1);
    end
  end

  AST_LINE_TAGS: assert property (@(posedge clk) disable iff (!rst_ni)
    o_valid |-> (o_first == (out_cnt == '0)) && (o_last == (out_cnt == QW'(PAIRS-1)))); // R9
  AST_TAIL_GAP: assert property (@(posedge clk) disable iff (!rst_ni)
    (o_valid && o_last) |=> !o_valid); // R9
  AST_TAIL_LATENCY: assert property (@(posedge clk) disable iff (!rst_ni)
    (o_valid && o_last) |-> $past(end_pulse, 8)); // R10
  AST_TAIL_PRESENT: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(end_pulse, 8) |-> (o_valid && o_last)); // R10
  AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_ni)
    !o_valid |-> ($stable(o_lo) && $stable(o_hi))); // R13
endmodule

bind dwt97_core dwt97_core_chk #(.LINE_LEN(LINE_LEN), .OW(SAMPLE_W+GUARD_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .i_valid(i_valid), .o_valid(o_valid),
  .o_first(o_first), .o_last(o_last), .o_lo(o_lo), .o_hi(o_hi)
);

// File: tb/sim_dwt97_core.sv
`timescale 1ns/1ps
module sim_dwt97_core;
  localparam int LINE_LEN = 8;
  localparam int SAMPLE_W = 12;
  localparam int GUARD_W  = 4;
  localparam int IW       = SAMPLE_W + GUARD_W;
  localparam int M        = LINE_LEN / 2;
  localparam longint CA = -25987, CB = -868, CG = 14466, CD = 7266;
  localparam longint CKL = 18835, CKH = 14252;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni = 1'b0;
  logic i_valid = 1'b0;
  logic signed [SAMPLE_W-1:0] i_sample = '0;
  logic o_valid, o_first, o_last;
  logic signed [IW-1:0] o_lo, o_hi;

  dwt97_core #(.LINE_LEN(LINE_LEN), .SAMPLE_W(SAMPLE_W), .GUARD_W(GUARD_W)) u0 (
    .clk(clk), .rst_ni(rst_ni), .i_valid(i_valid), .i_sample(i_sample),
    .o_valid(o_valid), .o_first(o_first), .o_last(o_last), .o_lo(o_lo), .o_hi(o_hi)
  );

  int checks = 0, errors = 0;
  int cyc = 0, in_idx = 0, lin_in = 0, lin_out = 0;
  int wp = 0, rp = 0;
  longint exp_lo [4096];
  longint exp_hi [4096];
  string  exp_tag [4096];
  int     end_cyc [1024];
  longint line_buf [LINE_LEN];
  longint prev_lo = 0, prev_hi = 0;
  bit     mon_en = 1'b0;

  task automatic check(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint wr(longint v);
    logic [IW-1:0] t;
    t = v[IW-1:0];
    return longint'($signed(t));
  endfunction

  function automatic longint lift(longint base, longint c, longint x, longint y);
    return wr(base + wr((c * (x + y)) >>> 14));
  endfunction

  // R2 R3 R4 R5 R6 R7 R8: integer model of one line
  task automatic push_model(string tag);
    longint e[M], o[M], d1[M], s1[M], d2[M], s2[M];
    for (int k = 0; k < M; k++) begin
      e[k] = line_buf[2*k];
      o[k] = line_buf[2*k+1];
    end
    for (int k = 0; k < M; k++) d1[k] = lift(o[k], CA, e[k], (k == M-1) ? e[k] : e[k+1]);
    for (int k = 0; k < M; k++) s1[k] = lift(e[k], CB, (k == 0) ? d1[0] : d1[k-1], d1[k]);
    for (int k = 0; k < M; k++) d2[k] = lift(d1[k], CG, s1[k], (k == M-1) ? s1[k] : s1[k+1]);
    for (int k = 0; k < M; k++) s2[k] = lift(s1[k], CD, (k == 0) ? d2[0] : d2[k-1], d2[k]);
    for (int k = 0; k < M; k++) begin
      exp_lo[wp]  = wr((CKL * s2[k]) >>> 14);
      exp_hi[wp]  = wr((CKH * d2[k]) >>> 14);
      exp_tag[wp] = tag;
      wp++;
    end
  endtask

  task automatic send_line(int gapmax, string tag);
    push_model(tag);
    for (int i = 0; i < LINE_LEN; i++) begin
      int gaps;
      gaps = (gapmax > 0) ? int'($urandom_range(0, gapmax)) : 0;
      repeat (gaps) begin
        @(negedge clk);
        i_valid  = 1'b0;
        i_sample = SAMPLE_W'($urandom);  // R11: garbage while idle
      end
      @(negedge clk);
      i_valid  = 1'b1;
      i_sample = SAMPLE_W'(line_buf[i]);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      i_valid  = 1'b0;
      i_sample = SAMPLE_W'($urandom);
    end
  endtask

  // input accept tracking: cycle index after the edge taking a line's final sample
  always @(posedge clk) begin
    cyc++;
    if (rst_ni && i_valid) begin
      if (in_idx == LINE_LEN-1) begin
        end_cyc[lin_in] = cyc;
        lin_in++;
        in_idx = 0;
      end else begin
        in_idx++;
      end
    end
  end

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (o_valid) begin
        if (rp >= wp) begin
          check(1'b0, "R9 extra strobe", rp, wp);
        end else begin
          int k;
          string pos;
          k = rp % M;
          pos = (k == 0) ? "R8" : (k == M-1) ? "R7" : "R3 R4 R5";
          check(longint'(o_lo) == exp_lo[rp], {exp_tag[rp], " ", pos, " R6 low"}, longint'(o_lo), exp_lo[rp]);
          check(longint'(o_hi) == exp_hi[rp], {exp_tag[rp], " ", pos, " R6 high"}, longint'(o_hi), exp_hi[rp]);
          check(o_first == (k == 0), "R9 first marker", longint'(o_first), longint'(k == 0));
          check(o_last == (k == M-1), "R9 last marker", longint'(o_last), longint'(k == M-1));
          if (o_last) begin
            check(cyc - end_cyc[lin_out] == 7, "R10 tail latency", cyc - end_cyc[lin_out], 7);
            lin_out++;
          end
          rp++;
        end
        prev_lo = longint'(o_lo);
        prev_hi = longint'(o_hi);
      end else begin
        check(longint'(o_lo) == prev_lo && longint'(o_hi) == prev_hi, "R13 hold",
              longint'(o_lo), prev_lo);
      end
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check(o_valid == 1'b0 && o_first == 1'b0 && o_last == 1'b0, "R1 flags in reset",
          longint'({o_valid, o_first, o_last}), 0);
    check(o_lo == '0 && o_hi == '0, "R1 data in reset", longint'(o_lo), 0);
    rst_ni = 1'b1;
    idle(4);
    check(o_valid == 1'b0 && o_lo == '0 && o_hi == '0, "R1 after release",
          longint'(o_valid), 0);
    mon_en = 1'b1;

    // R2 R7 R8: impulses at every position, both signs, isolated lines
    for (int p = 0; p < LINE_LEN; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < LINE_LEN; i++) line_buf[i] = (i == p) ? ((s == 0) ? 1500 : -1500) : 0;
        send_line(0, "R2");
        idle(10);
      end
    end

    // R12: impulses at every position, back to back with no idle cycles
    for (int p = 0; p < LINE_LEN; p++) begin
      for (int i = 0; i < LINE_LEN; i++) line_buf[i] = (i == p) ? -2048 : 2047;
      send_line(0, "R12");
    end
    idle(12);

    // extremes, constants and ramps
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < LINE_LEN; i++) begin
        case (c)
          0: line_buf[i] = (i % 2 == 0) ? 2047 : -2048;
          1: line_buf[i] = -2048;
          2: line_buf[i] = 2047;
          3: line_buf[i] = 1000;
          4: line_buf[i] = i * 500 - 2000;
          default: line_buf[i] = (i % 2 == 0) ? -2048 : 2047;
        endcase
      end
      send_line(0, "R3 R4 R6");
    end
    idle(12);

    // R11: the same line with and without pauses
    for (int i = 0; i < LINE_LEN; i++) line_buf[i] = longint'($signed(SAMPLE_W'($urandom)));
    send_line(0, "R11");
    idle(12);
    send_line(3, "R11");
    idle(12);

    // random lines, alternating gap-free streaming and random pauses
    for (int n = 0; n < 200; n++) begin
      for (int i = 0; i < LINE_LEN; i++) line_buf[i] = longint'($signed(SAMPLE_W'($urandom)));
      send_line((n % 2 == 0) ? 0 : 3, (n % 2 == 0) ? "R12" : "R11");
    end
    idle(20);

    // R9: every expected pair arrived, nothing more
    check(rp == wp, "R9 pair count", rp, wp);
    check(lin_out == lin_in, "R9 line count", lin_out, lin_in);
    finish_sim();
  end
endmodule